// File: doc/BRIEF.md
# Translation Lookaside Buffer

This block keeps a small, fully associative set of page translations for a memory management unit. A lookup presents a virtual address, tells whether it is a write, and gives the privilege of the requester. In the same cycle the block answers with one of three results. A hit gives the physical address. A miss means no valid translation is held. A fault means a user-mode access has reached a page marked supervisor-only.

Misses are not resolved inside the block. A slower handler outside it, such as a software routine, finds the mapping and installs it through a refill port. Every held translation carries four status flags: dirty, recently-used, supervisor-only and cacheable. Lookups that hit update the recently-used flag, and writes that hit also update the dirty flag. When a refill needs a slot, the recently-used flags pick the one to replace. A flush input empties the whole buffer.

Top module: `tlb_top`

## Requirements
- R1: After reset every slot is empty, so any lookup reports a miss.
- R2: When a valid lookup matches a valid slot and no fault applies, `lk_hit` is 1 in the same cycle. `lk_paddr` is then the slot's physical page number in bits [31:12] above the lookup's own bits [11:0]. At most one of `lk_hit`, `lk_miss` and `lk_fault` is 1, and with `lk_valid` high exactly one of them is.
- R3: When a valid lookup matches no valid slot, `lk_miss` is 1. Unless a hit is reported, `lk_paddr`, `lk_dirty` and `lk_cacheable` are 0.
- R4: A lookup with `lk_user`=1 that matches a slot installed with `fill_super`=1 reports `lk_fault` and changes no slot state. The same lookup with `lk_user`=0 hits.
- R5: A hit returns the slot's dirty flag on `lk_dirty`, as it stood before this access. A write hit (`lk_write`=1) sets that flag, while read hits and faults leave it alone. Installing a slot clears its dirty flag.
- R6: A hit returns on `lk_cacheable` the cacheable flag that was installed with the slot.
- R7: A refill whose page number is already held rewrites that slot and evicts nothing. A refill takes effect from the next cycle.
- R8: A refill of a page not yet held goes into the lowest-numbered slot whose recently-used flag is clear. Empty slots have that flag clear. A hit sets it, and so does installation.
- R9: When a refill finds every recently-used flag set, all the flags are cleared and slot 0 receives the new entry.
- R10: A flush empties every slot at the next clock edge. It overrides a refill presented in the same cycle.

Top module ports are listed in port-list order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Empty all slots at the next edge |
| lk_valid | input | 1 | Lookup request present |
| lk_vaddr | input | 32 | Lookup virtual address |
| lk_write | input | 1 | Lookup is a write |
| lk_user | input | 1 | Lookup comes from user mode |
| lk_hit | output | 1 | Translation found and permitted |
| lk_miss | output | 1 | No valid translation held |
| lk_fault | output | 1 | User access to a supervisor-only page |
| lk_paddr | output | 32 | Physical address on a hit, else 0 |
| lk_dirty | output | 1 | Dirty flag of the hit slot |
| lk_cacheable | output | 1 | Cacheable flag of the hit slot |
| fill_valid | input | 1 | Refill request present |
| fill_vpn | input | 20 | Virtual page number to install |
| fill_ppn | input | 20 | Physical page number to install |
| fill_super | input | 1 | Installed page is supervisor-only |
| fill_cacheable | input | 1 | Installed page is cacheable |

## Verification
Lookup results are combinational. The bench drives each request just after a falling edge and samples the results 1 ns later, before the rising edge that commits any update. A refill, flush or flag change takes hold at the next rising edge, so the bench updates its own slot model at that edge and checks the effect on a lookup in a later cycle. Directed sequences fill all sixteen slots to reach the all-flags-set replacement and the lowest-clear-slot replacement, and they also drive a flush together with a refill. Random operations over a pool of page numbers larger than the buffer are then checked against the model.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  typedef enum logic [1:0] {
    RES_NONE  = 2'd0,
    RES_HIT   = 2'd1,
    RES_MISS  = 2'd2,
    RES_FAULT = 2'd3
  } lk_res_e;
endpackage

// File: rtl/tlb_match.sv
module tlb_match #(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 20,
  parameter int IDX_W   = 4
) (
  input  logic [VPN_W-1:0]              key,
  input  logic [ENTRIES-1:0][VPN_W-1:0] tags,
  input  logic [ENTRIES-1:0]            valid,
  output logic                          found,
  output logic [IDX_W-1:0]              idx
);
  logic [ENTRIES-1:0] eq;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign eq[g] = valid[g] && (tags[g] == key);
  end

  always_comb begin
    found = |eq;
    idx   = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (eq[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int ENTRIES = 16,
  parameter int IDX_W   = 4
) (
  input  logic [ENTRIES-1:0] used,
  output logic               all_used,
  output logic [IDX_W-1:0]   idx
);
  always_comb begin
    all_used = &used;
    idx      = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!used[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/tlb_top.sv
module tlb_top
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int VA_W    = 32,
  parameter int OFF_W   = 12,
  parameter int PPN_W   = 20
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  flush,
  input  logic                  lk_valid,
  input  logic [VA_W-1:0]       lk_vaddr,
  input  logic                  lk_write,
  input  logic                  lk_user,
  output logic                  lk_hit,
  output logic                  lk_miss,
  output logic                  lk_fault,
  output logic [PPN_W+OFF_W-1:0] lk_paddr,
  output logic                  lk_dirty,
  output logic                  lk_cacheable,
  input  logic                  fill_valid,
  input  logic [VA_W-OFF_W-1:0] fill_vpn,
  input  logic [PPN_W-1:0]      fill_ppn,
  input  logic                  fill_super,
  input  logic                  fill_cacheable
);
  localparam int VPN_W = VA_W - OFF_W;
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0][VPN_W-1:0] vpn_q;
  logic [ENTRIES-1:0][PPN_W-1:0] ppn_q;
  logic [ENTRIES-1:0] valid_q, used_q, dirty_q, super_q, cache_q;
  logic [ENTRIES-1:0] valid_d, used_d, dirty_d;
  logic [ENTRIES-1:0] wr_en;

  logic             lk_found, fill_found, all_used;
  logic [IDX_W-1:0] lk_idx, fill_idx, vic_idx, tgt_idx;
  lk_res_e          lk_res;
  logic             do_fill;

  tlb_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .IDX_W(IDX_W)) u_lk_match (
    .key(lk_vaddr[VA_W-1:OFF_W]), .tags(vpn_q), .valid(valid_q),
    .found(lk_found), .idx(lk_idx)
  );

  tlb_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .IDX_W(IDX_W)) u_fill_match (
    .key(fill_vpn), .tags(vpn_q), .valid(valid_q),
    .found(fill_found), .idx(fill_idx)
  );

  tlb_victim #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_victim (
    .used(used_q), .all_used(all_used), .idx(vic_idx)
  );

  // lookup result
  always_comb begin
    if (!lk_valid)                         lk_res = RES_NONE;
    else if (!lk_found)                    lk_res = RES_MISS;
    else if (lk_user && super_q[lk_idx])   lk_res = RES_FAULT;
    else                                   lk_res = RES_HIT;
  end

  assign lk_hit       = (lk_res == RES_HIT);
  assign lk_miss      = (lk_res == RES_MISS);
  assign lk_fault     = (lk_res == RES_FAULT);
  assign lk_paddr     = lk_hit ? {ppn_q[lk_idx], lk_vaddr[OFF_W-1:0]} : '0;
  assign lk_dirty     = lk_hit && dirty_q[lk_idx];
  assign lk_cacheable = lk_hit && cache_q[lk_idx];

  assign do_fill = fill_valid && !flush;
  assign tgt_idx = fill_found ? fill_idx : vic_idx;

  // next state
  always_comb begin
    valid_d = valid_q;
    used_d  = used_q;
    dirty_d = dirty_q;
    wr_en   = '0;
    if (do_fill && !fill_found && all_used) used_d = '0;
    if (lk_hit) begin
      used_d[lk_idx] = 1'b1;
      if (lk_write) dirty_d[lk_idx] = 1'b1;
    end
    if (do_fill) begin
      wr_en[tgt_idx]   = 1'b1;
      valid_d[tgt_idx] = 1'b1;
      used_d[tgt_idx]  = 1'b1;
      dirty_d[tgt_idx] = 1'b0;
    end
    if (flush) begin
      valid_d = '0;
      used_d  = '0;
      dirty_d = '0;
    end
  end

  // status registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      used_q  <= '0;
      dirty_q <= '0;
    end else begin
      valid_q <= valid_d;
      used_q  <= used_d;
      dirty_q <= dirty_d;
    end
  end

  // payload registers, written only on install
  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (wr_en[g]) begin
        vpn_q[g]   <= fill_vpn;
        ppn_q[g]   <= fill_ppn;
        super_q[g] <= fill_super;
        cache_q[g] <= fill_cacheable;
      end
    end
  end
endmodule

// File: rtl/tlb_chk.sv
module tlb_chk #(
  parameter int VA_W  = 32,
  parameter int OFF_W = 12,
  parameter int PA_W  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              flush,
  input logic              lk_valid,
  input logic [VA_W-1:0]   lk_vaddr,
  input logic              lk_write,
  input logic              lk_hit,
  input logic              lk_miss,
  input logic              lk_fault,
  input logic [PA_W-1:0]   lk_paddr,
  input logic              lk_dirty,
  input logic              fill_valid,
  input logic [VA_W-OFF_W-1:0] fill_vpn
);
  // R2
  one_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |-> $countones({lk_hit, lk_miss, lk_fault}) == 1);

  // R2
  offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> lk_paddr[OFF_W-1:0] == lk_vaddr[OFF_W-1:0]);

  // R3
  nohit_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> (lk_paddr == '0) && !lk_dirty);

  // R7
  fill_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(fill_valid) && !$past(flush) && lk_valid &&
    lk_vaddr[VA_W-1:OFF_W] == $past(fill_vpn) |-> lk_hit || lk_fault);

  // R10
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(flush) && lk_valid |-> lk_miss);

  // R5
  dirty_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(lk_hit) && $past(lk_write) && !$past(fill_valid) && !$past(flush) &&
    lk_hit && lk_vaddr[VA_W-1:OFF_W] == $past(lk_vaddr[VA_W-1:OFF_W]) |-> lk_dirty);
endmodule

bind tlb_top tlb_chk #(.VA_W(VA_W), .OFF_W(OFF_W), .PA_W(PPN_W+OFF_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .lk_valid(lk_valid),
  .lk_vaddr(lk_vaddr), .lk_write(lk_write), .lk_hit(lk_hit),
  .lk_miss(lk_miss), .lk_fault(lk_fault), .lk_paddr(lk_paddr),
  .lk_dirty(lk_dirty), .fill_valid(fill_valid), .fill_vpn(fill_vpn)
);

// File: tb/tb_tlb_top.sv
`timescale 1ns/1ps
module tb_tlb_top;
  localparam int N = 16;

  logic        clk, rst_n, flush;
  logic        lk_valid, lk_write, lk_user;
  logic [31:0] lk_vaddr;
  logic        lk_hit, lk_miss, lk_fault, lk_dirty, lk_cacheable;
  logic [31:0] lk_paddr;
  logic        fill_valid, fill_super, fill_cacheable;
  logic [19:0] fill_vpn, fill_ppn;

  int checks = 0;
  int errors = 0;

  // bench model of the slots
  bit        m_valid [N];
  bit        m_used  [N];
  bit        m_dirty [N];
  bit        m_sup   [N];
  bit        m_cac   [N];
  bit [19:0] m_vpn   [N];
  bit [19:0] m_ppn   [N];

  tlb_top dut (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .lk_valid(lk_valid), .lk_vaddr(lk_vaddr), .lk_write(lk_write), .lk_user(lk_user),
    .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_fault(lk_fault), .lk_paddr(lk_paddr),
    .lk_dirty(lk_dirty), .lk_cacheable(lk_cacheable),
    .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
    .fill_super(fill_super), .fill_cacheable(fill_cacheable)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic int m_find(input bit [19:0] vpn);
    for (int i = 0; i < N; i++) if (m_valid[i] && m_vpn[i] == vpn) return i;
    return -1;
  endfunction

  function automatic void m_clear();
    for (int i = 0; i < N; i++) begin
      m_valid[i] = 0; m_used[i] = 0; m_dirty[i] = 0;
    end
  endfunction

  // want: 0 any, 1 hit, 2 miss, 3 fault
  task automatic lookup(input bit [31:0] va, input bit wr, input bit usr,
                        input int want, input string tag);
    int k;
    bit eh, em, ef, ed, ec;
    bit [31:0] ep;
    logic [36:0] act, exp;
    @(negedge clk);
    lk_valid = 1; lk_vaddr = va; lk_write = wr; lk_user = usr;
    #1;
    k  = m_find(va[31:12]);
    em = (k < 0);
    ef = !em && usr && m_sup[k];
    eh = !em && !ef;
    ep = eh ? {m_ppn[k], va[11:0]} : 32'h0;
    ed = eh && m_dirty[k];
    ec = eh && m_cac[k];
    act = {lk_hit, lk_miss, lk_fault, lk_dirty, lk_cacheable, lk_paddr};
    exp = {eh, em, ef, ed, ec, ep};
    check(act === exp, tag, 64'(act), 64'(exp));
    if (want != 0) begin
      logic [2:0] wv;
      wv = (want == 1) ? 3'b100 : (want == 2) ? 3'b010 : 3'b001;
      check({lk_hit, lk_miss, lk_fault} === wv, tag,
            64'({lk_hit, lk_miss, lk_fault}), 64'(wv));
    end
    @(posedge clk);
    if (eh) begin
      m_used[k] = 1;
      if (wr) m_dirty[k] = 1;
    end
    #1 lk_valid = 0;
  endtask

  task automatic fill(input bit [19:0] vpn, input bit [19:0] ppn, input bit sup,
                      input bit cac, input bit with_flush);
    int k;
    bit all;
    @(negedge clk);
    fill_valid = 1; fill_vpn = vpn; fill_ppn = ppn; fill_super = sup;
    fill_cacheable = cac; flush = with_flush;
    @(posedge clk);
    if (with_flush) m_clear();
    else begin
      k = m_find(vpn);
      if (k < 0) begin
        all = 1;
        for (int i = 0; i < N; i++) if (!m_used[i]) all = 0;
        if (all) begin
          for (int i = 0; i < N; i++) m_used[i] = 0;
          k = 0;
        end else begin
          for (int i = N - 1; i >= 0; i--) if (!m_used[i]) k = i;
        end
      end
      m_valid[k] = 1; m_used[k] = 1; m_dirty[k] = 0;
      m_vpn[k] = vpn; m_ppn[k] = ppn; m_sup[k] = sup; m_cac[k] = cac;
    end
    #1 fill_valid = 0; flush = 0;
  endtask

  task automatic do_flush();
    @(negedge clk);
    flush = 1;
    @(posedge clk);
    m_clear();
    #1 flush = 0;
  endtask

  initial begin
    #1600000;
    errors++;
    $display("FAIL watchdog act=%h exp=%h", 64'd0, 64'd1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    rst_n = 0; flush = 0; lk_valid = 0; lk_vaddr = '0; lk_write = 0; lk_user = 0;
    fill_valid = 0; fill_vpn = '0; fill_ppn = '0; fill_super = 0; fill_cacheable = 0;
    m_clear();
    repeat (3) @(posedge clk);
    #2 rst_n = 1;

    // R1 reset state
    lookup(32'h0000_0123, 0, 0, 2, "R1 reset miss");
    lookup(32'h1234_5678, 0, 1, 2, "R1 reset miss user");

    // R2 R6 basic hit and cacheable flag
    fill(20'h00ABC, 20'h55555, 0, 1, 0);
    lookup(32'h00AB_C7F3, 0, 1, 1, "R2 hit paddr");
    lookup(32'h00AB_C000, 0, 0, 1, "R6 cacheable hit");
    fill(20'h00ABD, 20'h12345, 0, 0, 0);
    lookup(32'h00AB_DFFF, 0, 0, 1, "R6 non-cacheable hit");
    // R3 miss
    lookup(32'h00AB_E000, 0, 0, 2, "R3 miss");

    // R4 protection fault, R5 fault leaves dirty alone
    fill(20'h00F00, 20'hF0F0F, 1, 1, 0);
    lookup(32'h00F0_0010, 1, 1, 3, "R4 user fault");
    lookup(32'h00F0_0010, 0, 0, 1, "R4 supervisor hit");
    check(lk_dirty === 1'b0, "R5 fault kept clean", 64'(lk_dirty), 64'd0);

    // R5 dirty flag
    lookup(32'h00AB_C004, 0, 0, 1, "R5 read hit");
    lookup(32'h00AB_C008, 1, 0, 1, "R5 write hit clean");
    lookup(32'h00AB_C00C, 0, 0, 1, "R5 dirty shown");
    check(m_dirty[m_find(20'h00ABC)] == 1, "R5 model dirty", 0, 1);
    // R7 refill of held page rewrites in place and clears dirty
    fill(20'h00ABC, 20'h77777, 0, 1, 0);
    lookup(32'h00AB_C00C, 0, 0, 1, "R7 rewrite new ppn");
    check(lk_paddr === 32'h7777_700C, "R7 paddr", 64'(lk_paddr), 64'h7777_700C);

    // R10 flush, and flush beats fill
    do_flush();
    lookup(32'h00AB_C000, 0, 0, 2, "R10 flush miss");
    fill(20'h00321, 20'h00001, 0, 0, 1);
    lookup(32'h0032_1000, 0, 0, 2, "R10 flush over fill");

    // R8 R9 replacement
    for (int i = 0; i < N; i++) fill(20'h01000 + 20'(i), 20'h20000 + 20'(i), 0, 0, 0);
    for (int i = 0; i < N; i++) lookup({20'h01000 + 20'(i), 12'h0}, 0, 0, 1, "R8 all held");
    fill(20'h01005, 20'h3AAAA, 0, 0, 0);
    lookup(32'h0100_F000, 0, 0, 1, "R7 no eviction");
    fill(20'h02000, 20'h3BBBB, 0, 0, 0);
    lookup(32'h0100_0000, 0, 0, 2, "R9 slot0 evicted");
    lookup(32'h0200_0000, 0, 0, 1, "R9 new in slot0");
    lookup(32'h0100_1000, 0, 0, 1, "R8 touch 1");
    lookup(32'h0100_2000, 0, 0, 1, "R8 touch 2");
    lookup(32'h0100_3000, 0, 0, 1, "R8 touch 3");
    fill(20'h02001, 20'h3CCCC, 0, 0, 0);
    lookup(32'h0100_4000, 0, 0, 2, "R8 lowest clear evicted");
    lookup(32'h0100_6000, 0, 0, 1, "R8 others kept");
    lookup(32'h0200_1000, 0, 0, 1, "R8 new held");

    // random mix against the model
    for (int n = 0; n < 3000; n++) begin
      int r;
      bit [19:0] v;
      r = $urandom % 32;
      v = 20'h04000 + 20'($urandom % 24);
      if (r == 0) do_flush();
      else if (r < 9) fill(v, 20'($urandom), ($urandom % 4) == 0, 1'($urandom), 0);
      else lookup({v, 12'($urandom)}, 1'($urandom), 1'($urandom), 0, "R2 R3 R4 R5 R8 random");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule